// File: doc/BRIEF.md
# Linked-Tag Source Chain Walker

This block is the control engine of one source-chain DMA channel. It does not move data. It walks a linked list of descriptor tags in memory. Each tag is fetched from the current tag address. From the tag's 3-bit type the block works out three things: where the payload lives, how many 16-byte quadwords it holds, and where the next tag is. It then asks an external data engine to move the payload. A two-entry return-address stack lets a chain call a sub-list and come back from it. The chain stops at an ending tag type, at an interrupt-flagged tag, at a return with an empty stack, at a zero tag address, or when a call overflows the stack.

Software loads a start address, a start count and a tag address, and pulses start. If the start count is zero, the walker fetches its first tag right away and runs no end test before that fetch. If the start count is non-zero, the walker first moves that payload. It then applies the end tests to the tag it latched last; that latched tag reads as all zero after reset. A data request can be only partly accepted. In that case the walker parks with the rest of the count and goes on when resume is pulsed. It does not fetch a new tag for this. When the chain stops, the walker drops busy and gives a one-cycle interrupt pulse.

Both request ports are valid/ready. Once valid is high, the walker holds it and keeps the address and count stable until ready is seen. A tag fetch has only one response outstanding. The response is a single-cycle valid with no ready, and it is taken only while the walker waits for it. A data request completes in the cycle ready is high. The accepted-count input in that same cycle must not be larger than the requested count.

Top module: `chain_walker`

## Requirements
- R1: After reset, busy, interrupt, error, latched tag, stack depth and both request valids are all zero.
- R2: Tag fields are: count in bits 15:0, type in bits 30:28, interrupt flag in bit 31, and address in bits 63:32 with its low 4 bits cleared. Bits 31:16 of each fetched tag appear on the latched-tag output.
- R3: Type codes are REFE=0, CNT=1, NEXT=2, REF=3, REFS=4, CALL=5, RET=6, END=7. For REFE, REF and REFS, the payload is at the tag address field, and the next tag is at the current tag address + 0x10. REFE ends the chain once its payload is done.
- R4: For CNT, the payload starts at tag address + 0x10, and the next tag follows the payload (payload address + count×16). For NEXT, the payload follows the tag, and the next tag address is the tag's address field.
- R5: For CALL, the payload follows the tag. The address past the payload is pushed, and the next tag comes from the address field. A CALL that finds two entries already stacked sets the error output and stops the chain.
- R6: For RET, the payload follows the tag. A non-empty stack pops into the tag address. An empty stack leaves the tag address unchanged and ends the chain once the payload is done.
- R7: END ends the chain after its payload. Once the count reaches zero, a latched tag with bit 31 set also ends the chain, but only if interrupt enable was high at start.
- R8: A zero tag address at fetch time ends the chain without a fetch.
- R9: A start with count zero fetches a tag without testing the latched tag. A start with a non-zero count moves that payload first and then tests the latched tag. A start clears the error, the stack and the empty-return condition.
- R10: An accepted count below the requested one advances the address and count by the accepted amount. The walker then waits for resume, with no new tag fetch, and then requests the remainder.
- R11: A start pulse while busy has no effect on the address, count or tag address.
- R12: Requests hold valid, address and count until ready. The interrupt is one cycle long and coincides with busy falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start pulse, used only when idle |
| tie_i | input | 1 | Tag interrupt enable, captured at start |
| start_madr_i | input | 32 | Payload address loaded at start |
| start_qwc_i | input | 16 | Quadword count loaded at start |
| start_tadr_i | input | 32 | Tag address loaded at start |
| resume_i | input | 1 | Continue a parked partial transfer |
| tag_req_valid_o | output | 1 | Tag fetch request valid |
| tag_req_ready_i | input | 1 | Tag fetch request accepted |
| tag_req_addr_o | output | 32 | Tag fetch address |
| tag_rsp_valid_i | input | 1 | Tag data valid (one cycle) |
| tag_rsp_data_i | input | 64 | Lower 64 bits of the fetched tag |
| xfer_valid_o | output | 1 | Data transfer request valid |
| xfer_ready_i | input | 1 | Data transfer request completes |
| xfer_addr_o | output | 32 | Payload address |
| xfer_qwc_o | output | 16 | Quadwords requested |
| xfer_acc_i | input | 16 | Quadwords accepted when ready |
| busy_o | output | 1 | Channel running |
| irq_o | output | 1 | One-cycle chain-end pulse |
| err_o | output | 1 | Stack overflow on CALL |
| tag_o | output | 16 | Latched upper tag half |
| asp_o | output | 2 | Return stack depth |
| madr_o | output | 32 | Current payload address |
| qwc_o | output | 16 | Remaining count |
| tadr_o | output | 32 | Current tag address |

## Verification
Two functions meet on one tag decode. A RET that pops the stack sets the next tag address, and the end test runs on the same tag once its count is used up. A RET on an empty stack must end the chain, while a popping RET must not. The bench runs a chain in which RETs pop back to back, and a separate RET with an empty stack whose payload is also split by a partial acceptance. It then judges the transfer log, the final tag address, the stack depth and the fetch count against values worked out by hand.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [2:0] {
    TG_REFE = 3'd0,
    TG_CNT  = 3'd1,
    TG_NEXT = 3'd2,
    TG_REF  = 3'd3,
    TG_REFS = 3'd4,
    TG_CALL = 3'd5,
    TG_RET  = 3'd6,
    TG_END  = 3'd7
  } tag_id_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_FETCH,
    S_WAIT,
    S_XFER,
    S_SUSP
  } walk_st_e;

  localparam int QW_W     = 16;
  localparam int TAG_W    = 64;
  localparam int QW_BYTES = 16;
endpackage

// File: rtl/cw_tag_decode.sv
module cw_tag_decode
  import cw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [TAG_W-1:0] tag_i,
  input  logic [AW-1:0]    cur_tadr_i,
  input  logic [AW-1:0]    stack_top_i,
  input  logic             stack_empty_i,
  input  logic             stack_full_i,
  output logic [AW-1:0]    nx_madr_o,
  output logic [QW_W-1:0]  nx_qwc_o,
  output logic [AW-1:0]    nx_tadr_o,
  output logic             push_o,
  output logic [AW-1:0]    push_addr_o,
  output logic             pop_o,
  output logic             set_rettop_o,
  output logic             overflow_o,
  output logic [15:0]      tag_hi_o
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(QW_BYTES - 1);

  tag_id_e         id;
  logic [AW-1:0]   field_addr;
  logic [AW-1:0]   after_tag;
  logic [AW-1:0]   span;
  logic [QW_W-1:0] cnt;

  always_comb begin
    id          = tag_id_e'(tag_i[30:28]);
    cnt         = tag_i[QW_W-1:0];
    field_addr  = tag_i[32 +: AW] & ALIGN_MASK;
    after_tag   = cur_tadr_i + AW'(QW_BYTES);
    span        = AW'({cnt, 4'b0000});
    tag_hi_o    = tag_i[31:16];

    nx_madr_o    = after_tag;
    nx_qwc_o     = cnt;
    nx_tadr_o    = cur_tadr_i;
    push_o       = 1'b0;
    push_addr_o  = after_tag + span;
    pop_o        = 1'b0;
    set_rettop_o = 1'b0;
    overflow_o   = 1'b0;

    case (id)
      TG_REFE, TG_REF, TG_REFS: begin
        nx_madr_o = field_addr;
        nx_tadr_o = after_tag;
      end
      TG_CNT: begin
        nx_tadr_o = after_tag + span;
      end
      TG_NEXT: begin
        nx_tadr_o = field_addr;
      end
      TG_CALL: begin
        nx_tadr_o  = field_addr;
        push_o     = !stack_full_i;
        overflow_o = stack_full_i;
      end
      TG_RET: begin
        if (!stack_empty_i) begin
          pop_o     = 1'b1;
          nx_tadr_o = stack_top_i;
        end else begin
          set_rettop_o = 1'b1;
        end
      end
      default: begin
        nx_tadr_o = cur_tadr_i;
      end
    endcase
  end
endmodule

// File: rtl/cw_ret_stack.sv
module cw_ret_stack #(
  parameter int AW    = 32,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [AW-1:0]    push_addr_i,
  output logic [AW-1:0]    top_o,
  output logic [$clog2(DEPTH+1)-1:0] asp_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int ASP_W = $clog2(DEPTH + 1);

  logic [ASP_W-1:0] asp;
  logic [AW-1:0]    ent [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asp <= '0;
    end else if (clear_i) begin
      asp <= '0;
    end else if (push_i && !full_o) begin
      asp <= asp + ASP_W'(1);
    end else if (pop_i && !empty_o) begin
      asp <= asp - ASP_W'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent[g] <= '0;
      end else if (push_i && !clear_i && asp == ASP_W'(g)) begin
        ent[g] <= push_addr_i;
      end
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (asp == ASP_W'(i + 1)) top_o = ent[i];
    end
  end

  assign asp_o   = asp;
  assign empty_o = (asp == '0);
  assign full_o  = (asp == ASP_W'(DEPTH));

  p_asp_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    asp <= ASP_W'(DEPTH));

  p_push_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clear_i && !full_o) |=> (asp == $past(asp) + ASP_W'(1)));

  p_pop_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !clear_i && !empty_o) |=> (asp == $past(asp) - ASP_W'(1)));
endmodule

// File: rtl/cw_end_check.sv
module cw_end_check
  import cw_pkg::*;
(
  input  logic [15:0] tag_hi_i,
  input  logic        tie_i,
  input  logic        rettop_i,
  input  logic        initxfer_i,
  output logic        end_o
);
  tag_id_e id;
  logic    by_type;
  logic    by_irq;

  always_comb begin
    id      = tag_id_e'(tag_hi_i[14:12]);
    by_type = (id == TG_REFE) || (id == TG_END);
    by_irq  = tie_i && tag_hi_i[15];
    end_o   = !initxfer_i && (by_type || by_irq || rettop_i);
  end
endmodule

// File: rtl/chain_walker.sv
module chain_walker
  import cw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       tie_i,
  input  logic [AW-1:0]              start_madr_i,
  input  logic [15:0]                start_qwc_i,
  input  logic [AW-1:0]              start_tadr_i,
  input  logic                       resume_i,
  output logic                       tag_req_valid_o,
  input  logic                       tag_req_ready_i,
  output logic [AW-1:0]              tag_req_addr_o,
  input  logic                       tag_rsp_valid_i,
  input  logic [63:0]                tag_rsp_data_i,
  output logic                       xfer_valid_o,
  input  logic                       xfer_ready_i,
  output logic [AW-1:0]              xfer_addr_o,
  output logic [15:0]                xfer_qwc_o,
  input  logic [15:0]                xfer_acc_i,
  output logic                       busy_o,
  output logic                       irq_o,
  output logic                       err_o,
  output logic [15:0]                tag_o,
  output logic [$clog2(DEPTH+1)-1:0] asp_o,
  output logic [AW-1:0]              madr_o,
  output logic [15:0]                qwc_o,
  output logic [AW-1:0]              tadr_o
);
  localparam int ASP_W = $clog2(DEPTH + 1);

  walk_st_e        st;
  logic            busy_q, irq_q, err_q, tie_q, rettop_q, initxfer_q;
  logic [AW-1:0]   madr_q, tadr_q;
  logic [QW_W-1:0] qwc_q;
  logic [15:0]     tag_hi_q;

  logic [AW-1:0]   nx_madr, nx_tadr, push_addr, stk_top;
  logic [QW_W-1:0] nx_qwc;
  logic            dec_push, dec_pop, dec_rettop, dec_ovf;
  logic [15:0]     dec_tag_hi;
  logic            stk_empty, stk_full;
  logic [ASP_W-1:0] stk_asp;
  logic            end_now;
  logic            take_rsp, start_ok, stk_push, stk_pop;

  assign take_rsp = (st == S_WAIT) && tag_rsp_valid_i;
  assign start_ok = (st == S_IDLE) && start_i;
  assign stk_push = take_rsp && dec_push && !dec_ovf;
  assign stk_pop  = take_rsp && dec_pop;

  cw_tag_decode #(.AW(AW)) u_dec (
    .tag_i        (tag_rsp_data_i),
    .cur_tadr_i   (tadr_q),
    .stack_top_i  (stk_top),
    .stack_empty_i(stk_empty),
    .stack_full_i (stk_full),
    .nx_madr_o    (nx_madr),
    .nx_qwc_o     (nx_qwc),
    .nx_tadr_o    (nx_tadr),
    .push_o       (dec_push),
    .push_addr_o  (push_addr),
    .pop_o        (dec_pop),
    .set_rettop_o (dec_rettop),
    .overflow_o   (dec_ovf),
    .tag_hi_o     (dec_tag_hi)
  );

  cw_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_ok),
    .push_i     (stk_push),
    .pop_i      (stk_pop),
    .push_addr_i(push_addr),
    .top_o      (stk_top),
    .asp_o      (stk_asp),
    .empty_o    (stk_empty),
    .full_o     (stk_full)
  );

  cw_end_check u_end (
    .tag_hi_i  (tag_hi_q),
    .tie_i     (tie_q),
    .rettop_i  (rettop_q),
    .initxfer_i(initxfer_q),
    .end_o     (end_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      busy_q     <= 1'b0;
      irq_q      <= 1'b0;
      err_q      <= 1'b0;
      tie_q      <= 1'b0;
      rettop_q   <= 1'b0;
      initxfer_q <= 1'b0;
      madr_q     <= '0;
      tadr_q     <= '0;
      qwc_q      <= '0;
      tag_hi_q   <= '0;
    end else begin
      irq_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_i) begin
            busy_q     <= 1'b1;
            err_q      <= 1'b0;
            rettop_q   <= 1'b0;
            tie_q      <= tie_i;
            madr_q     <= start_madr_i;
            qwc_q      <= start_qwc_i;
            tadr_q     <= start_tadr_i;
            initxfer_q <= (start_qwc_i == '0);
            st         <= (start_qwc_i != '0) ? S_XFER : S_CHECK;
          end
        end
        S_CHECK: begin
          if (initxfer_q) begin
            initxfer_q <= 1'b0;
            st         <= S_FETCH;
          end else if (end_now) begin
            rettop_q <= 1'b0;
            busy_q   <= 1'b0;
            irq_q    <= 1'b1;
            st       <= S_IDLE;
          end else begin
            st <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (tadr_q == '0) begin
            busy_q <= 1'b0;
            irq_q  <= 1'b1;
            st     <= S_IDLE;
          end else if (tag_req_ready_i) begin
            st <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (tag_rsp_valid_i) begin
            tag_hi_q <= dec_tag_hi;
            if (dec_ovf) begin
              err_q  <= 1'b1;
              busy_q <= 1'b0;
              irq_q  <= 1'b1;
              st     <= S_IDLE;
            end else begin
              madr_q   <= nx_madr;
              qwc_q    <= nx_qwc;
              tadr_q   <= nx_tadr;
              rettop_q <= rettop_q | dec_rettop;
              st       <= (nx_qwc != '0) ? S_XFER : S_CHECK;
            end
          end
        end
        S_XFER: begin
          if (xfer_ready_i) begin
            madr_q <= madr_q + AW'({xfer_acc_i, 4'b0000});
            qwc_q  <= qwc_q - xfer_acc_i;
            st     <= (xfer_acc_i >= qwc_q) ? S_CHECK : S_SUSP;
          end
        end
        S_SUSP: begin
          if (resume_i) st <= S_XFER;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign tag_req_valid_o = (st == S_FETCH) && (tadr_q != '0);
  assign tag_req_addr_o  = tadr_q;
  assign xfer_valid_o    = (st == S_XFER);
  assign xfer_addr_o     = madr_q;
  assign xfer_qwc_o      = qwc_q;
  assign busy_o          = busy_q;
  assign irq_o           = irq_q;
  assign err_o           = err_q;
  assign tag_o           = tag_hi_q;
  assign asp_o           = stk_asp;
  assign madr_o          = madr_q;
  assign qwc_o           = qwc_q;
  assign tadr_o          = tadr_q;

  p_treq_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_req_valid_o && !tag_req_ready_i) |=> (tag_req_valid_o && $stable(tag_req_addr_o)));

  p_xfer_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !xfer_ready_i) |=> (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_qwc_o)));

  p_xfer_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |-> (xfer_qwc_o != '0));

  p_irq_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (!busy_o && $past(busy_o)));

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !irq_o && xfer_valid_o) |=> $stable(tadr_o));
endmodule

// File: tb/chain_walker_tb.sv
`timescale 1ns/1ps
module chain_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, tie_i = 1'b0, resume_i = 1'b0;
  logic [31:0] start_madr_i = '0, start_tadr_i = '0;
  logic [15:0] start_qwc_i = '0;
  logic        tag_req_valid_o, tag_req_ready_i;
  logic [31:0] tag_req_addr_o;
  logic        tag_rsp_valid_i = 1'b0;
  logic [63:0] tag_rsp_data_i = '0;
  logic        xfer_valid_o, xfer_ready_i;
  logic [31:0] xfer_addr_o;
  logic [15:0] xfer_qwc_o;
  logic [15:0] xfer_acc_i = '0;
  logic        busy_o, irq_o, err_o;
  logic [15:0] tag_o, qwc_o;
  logic [1:0]  asp_o;
  logic [31:0] madr_o, tadr_o;

  assign tag_req_ready_i = 1'b1;
  assign xfer_ready_i    = 1'b1;

  always #2 clk = ~clk;

  chain_walker u_dut (.*);

  int checks = 0, errors = 0;
  logic [63:0] tmem [256];
  logic [31:0] xa [32];
  logic [15:0] xq [32];
  int xn = 0, fn = 0, irqn = 0;
  int limit = 65535;
  logic rsp_pend = 1'b0;
  logic [7:0] pend_idx = '0;

  // expected transfers of the main chain: {address, count}
  localparam logic [47:0] MAIN_XFER [7] = '{
    {32'h0000_0110, 16'd2}, {32'h0000_0140, 16'd1}, {32'h0000_0210, 16'd1},
    {32'h0000_5000, 16'd3}, {32'h0000_03A0, 16'd1}, {32'h0000_6000, 16'd2},
    {32'h0000_7000, 16'd1}};

  function automatic logic [63:0] mk(input logic [2:0] id, input logic irq,
                                     input logic [15:0] q, input logic [31:0] a);
    return {a, irq, id, 12'h000, q};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    xn = 0; fn = 0; irqn = 0;
  endtask

  task automatic start(input logic [31:0] madr, input logic [15:0] q,
                       input logic [31:0] tadr, input logic tie);
    @(negedge clk);
    start_i = 1'b1; start_madr_i = madr; start_qwc_i = q;
    start_tadr_i = tadr; tie_i = tie;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  // memory and data-engine model, driven away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_pend) begin
        tag_rsp_valid_i = 1'b1;
        tag_rsp_data_i  = tmem[pend_idx];
        rsp_pend = 1'b0;
      end else begin
        tag_rsp_valid_i = 1'b0;
      end
      if (tag_req_valid_o) begin
        fn++;
        pend_idx = tag_req_addr_o[11:4];
        rsp_pend = 1'b1;
      end
      if (xfer_valid_o) begin
        xfer_acc_i = (int'(xfer_qwc_o) < limit) ? xfer_qwc_o : 16'(limit);
        if (xn < 32) begin
          xa[xn] = xfer_addr_o; xq[xn] = xfer_qwc_o;
        end
        xn++;
      end
      if (irq_o) irqn++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) tmem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy_o, 0); chk("R1 irq", irq_o, 0); chk("R1 err", err_o, 0);
    chk("R1 tag", tag_o, 0);   chk("R1 asp", asp_o, 0);
    chk("R1 reqs", {tag_req_valid_o, xfer_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // main chain: R3 R4 R5 R6 (stacked calls and popping returns)
    tmem[8'h10] = mk(3'd1, 0, 16'd2, 32'h0);
    tmem[8'h13] = mk(3'd2, 0, 16'd1, 32'h0000_0200);
    tmem[8'h20] = mk(3'd5, 0, 16'd1, 32'h0000_0300);
    tmem[8'h30] = mk(3'd5, 0, 16'd0, 32'h0000_0380);
    tmem[8'h38] = mk(3'd3, 0, 16'd3, 32'h0000_500F);
    tmem[8'h39] = mk(3'd6, 0, 16'd1, 32'h0);
    tmem[8'h31] = mk(3'd6, 0, 16'd0, 32'h0);
    tmem[8'h22] = mk(3'd4, 0, 16'd2, 32'h0000_6000);
    tmem[8'h23] = mk(3'd0, 0, 16'd1, 32'h0000_7000);
    clear_logs();
    start(32'h0, 16'd0, 32'h0000_0100, 1'b0);
    wait_idle();
    chk("R3 R4 R5 R6 xfer count", xn, 7);
    for (int i = 0; i < 7; i++)
      chk("R3 R4 R5 R6 xfer", {xa[i], xq[i]}, MAIN_XFER[i]);
    chk("R3 refe next tadr", tadr_o, 32'h240);
    chk("R6 stack drained", asp_o, 0);
    chk("R3 fetches", fn, 9);
    chk("R12 one irq", irqn, 1);
    chk("R2 latched tag refe", tag_o, 16'h0000);

    // R6 empty-stack RET, R10 partial accept, R11 start while busy
    tmem[8'h40] = mk(3'd6, 0, 16'd2, 32'h0);
    clear_logs();
    limit = 1;
    start(32'h0, 16'd0, 32'h0000_0400, 1'b0);
    repeat (8) @(negedge clk);
    limit = 65535;
    chk("R10 parked busy", busy_o, 1);
    chk("R10 madr advanced", madr_o, 32'h420);
    chk("R10 qwc left", qwc_o, 16'd1);
    start(32'h000D_EAD0, 16'd5, 32'h0000_0900, 1'b0);
    repeat (2) @(negedge clk);
    chk("R11 madr kept", madr_o, 32'h420);
    chk("R11 qwc kept", qwc_o, 16'd1);
    chk("R11 tadr kept", tadr_o, 32'h400);
    resume_i = 1'b1; @(negedge clk); resume_i = 1'b0;
    wait_idle();
    chk("R10 remainder", {xa[1], xq[1]}, {32'h420, 16'd1});
    chk("R10 no new fetch", fn, 1);
    chk("R6 rettop ends", busy_o, 0);
    chk("R6 tadr unchanged", tadr_o, 32'h400);

    // R7 interrupt-flag end with tie set, then without
    tmem[8'h50] = mk(3'd1, 1, 16'd1, 32'h0);
    tmem[8'h52] = mk(3'd7, 0, 16'd0, 32'h0);
    clear_logs();
    start(32'h0, 16'd0, 32'h0000_0500, 1'b1);
    wait_idle();
    chk("R7 irq-tag fetches", fn, 1);
    chk("R7 irq-tag xfer", {xa[0], xq[0]}, {32'h510, 16'd1});
    chk("R2 latched tag irq", tag_o, 16'h9000);
    clear_logs();
    start(32'h0, 16'd0, 32'h0000_0500, 1'b0);
    wait_idle();
    chk("R7 tie off continues", fn, 2);
    chk("R7 end tag", tag_o, 16'h7000);
    chk("R7 end tadr", tadr_o, 32'h520);

    // R9 start with count: data first, then latched END ends
    clear_logs();
    start(32'h0000_0800, 16'd2, 32'h0000_0900, 1'b0);
    wait_idle();
    chk("R9 start data", {xa[0], xq[0]}, {32'h800, 16'd2});
    chk("R9 no fetch", fn, 0);

    // R9 start with zero count skips the END test on the latched tag
    tmem[8'h60] = mk(3'd7, 0, 16'd1, 32'h0);
    clear_logs();
    start(32'h0, 16'd0, 32'h0000_0600, 1'b0);
    wait_idle();
    chk("R9 initxfer fetch", fn, 1);
    chk("R9 end data", {xa[0], xq[0]}, {32'h610, 16'd1});

    // R5 overflow
    tmem[8'hA0] = mk(3'd5, 0, 16'd0, 32'h0000_0A40);
    tmem[8'hA4] = mk(3'd5, 0, 16'd0, 32'h0000_0A80);
    tmem[8'hA8] = mk(3'd5, 0, 16'd0, 32'h0000_0AC0);
    clear_logs();
    start(32'h0, 16'd0, 32'h0000_0A00, 1'b0);
    wait_idle();
    chk("R5 overflow err", err_o, 1);
    chk("R5 overflow asp", asp_o, 2);
    chk("R5 overflow stop", {busy_o, 32'(irqn)}, {1'b0, 32'd1});

    // R8 zero tag address, R9 start clears error and stack
    clear_logs();
    start(32'h0, 16'd0, 32'h0, 1'b0);
    wait_idle();
    chk("R8 no fetch", fn, 0);
    chk("R8 irq", irqn, 1);
    chk("R9 err cleared", err_o, 0);
    chk("R9 asp cleared", asp_o, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule